// File: doc/BRIEF.md
# Nibble-Serial Bitwise AND/XOR Unit

This block computes the bitwise AND or XOR of two operands over several clock cycles, one limb at a time, starting from the most significant limb. Each cycle it emits a full trace row: a first-row flag, a not-last-row flag, the operands rebuilt so far, the bits of the current limb of each operand, the accumulator value of the previous row and the current accumulator. A consumer that records or checks such row-by-row traces attaches to the row outputs. A consumer that only needs the result waits for `done_o`.

An operation begins when `start_i` is seen while the unit is idle or on its final row. The operands and the operation select are captured at that edge. Row 0 appears on the following cycle, and the unit then advances one row per cycle. With the default widths, an operation is 32 bits wide and uses eight 4-bit limbs, so it takes eight rows. On the final row the accumulator holds the result and the rebuilt operands equal the original inputs.

Top module: `bw_nibble_unit`

## Requirements
- R1: While `rst_ni` is low, every output is zero: the trace values, both flags, `row_vld_o` and `done_o`.
- R2: After `start_i` is accepted, rows 0 to ROWS-1 appear on ROWS consecutive cycles, with `row_vld_o` high. ROWS = DATA_W/LIMB_W. `k0_o` is 1 only on row 0. `k1_o` is 1 on every row except the last.
- R3: Limbs are taken from the most significant end. On row r, `a_acc_o` equals a >> (DATA_W-(r+1)*LIMB_W), and `b_acc_o` follows the same rule for b. Each row's value is therefore 2^LIMB_W times the previous row's value plus the new limb, and on the last row it is the full operand.
- R4: `a_bits_o` and `b_bits_o` carry the current limb of each operand, with bit i of the port weighted 2^i.
- R5: On row r, `z_o` equals (the op applied to a and b) >> (DATA_W-(r+1)*LIMB_W). `zp_o` is 0 on row 0, and on every later row it equals the `z_o` of the row before.
- R6: `sel_i` = 0 selects AND and `sel_i` = 1 selects XOR. The select is latched with the start, so changes to `sel_i` during an operation have no effect on its rows.
- R7: `done_o` is high exactly on the last row of an operation. On that row `z_o` is the full result.
- R8: A `start_i` seen on any row other than the last is ignored. The running operation's rows and result are unchanged.
- R9: A `start_i` seen on the last row (the `done_o` cycle) starts a new operation, whose row 0 appears on the next cycle.
- R10: If no start comes on the last row, the unit goes idle on the next cycle. In that state `row_vld_o`, `k0_o`, `k1_o` and `done_o` are low, and the trace registers hold the last row's values.
- R11: With 16-bit operands and 4-bit limbs, 41851 AND 40426 gives `z_o` values of 8, 129, 2070 and 33130 on rows 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an operation |
| sel_i | input | 1 | Operation select: 0 = AND, 1 = XOR |
| a_i | input | DATA_W | Operand a |
| b_i | input | DATA_W | Operand b |
| row_vld_o | output | 1 | A trace row is being presented |
| k0_o | output | 1 | First-row flag |
| k1_o | output | 1 | Not-last-row flag |
| a_acc_o | output | DATA_W | Operand a rebuilt so far |
| b_acc_o | output | DATA_W | Operand b rebuilt so far |
| a_bits_o | output | LIMB_W | Current limb of a |
| b_bits_o | output | LIMB_W | Current limb of b |
| zp_o | output | DATA_W | Accumulator of the previous row |
| z_o | output | DATA_W | Accumulator of the current row |
| done_o | output | 1 | Last row; `z_o` holds the result |

## Verification
The main instance is built with DATA_W=6 and LIMB_W=2, which gives three rows per operation. This makes every operand pair for both operations reachable, and each operation is checked on every row. During half of these operations the bench injects starts and changes to the select mid-operation. Operations are chained back to back, with an idle gap after each operand-a sweep. A second instance is built with DATA_W=16 and LIMB_W=4 and reproduces the four-row worked case with AND.

// File: rtl/bw_pkg.sv
package bw_pkg;
  typedef enum logic {
    OP_AND = 1'b0,
    OP_XOR = 1'b1
  } bw_op_e;
endpackage

// File: rtl/bw_row_ctrl.sv
module bw_row_ctrl #(
  parameter int ROWS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic vld_o,
  output logic k0_o,
  output logic k1_o,
  output logic last_o
);
  localparam int CNT_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [CNT_W-1:0] LAST_ROW = CNT_W'(ROWS - 1);

  logic             busy_q;
  logic [CNT_W-1:0] row_q;
  logic             last;

  assign last     = busy_q && (row_q == LAST_ROW);
  assign accept_o = start_i && (!busy_q || last);
  assign step_o   = busy_q && !last;
  assign vld_o    = busy_q;
  assign k0_o     = busy_q && (row_q == '0);
  assign k1_o     = step_o;
  assign last_o   = last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      row_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      row_q  <= '0;
    end else if (step_o) begin
      row_q  <= row_q + 1'b1;
    end else if (last) begin
      busy_q <= 1'b0;
    end
  end

  // R8
  mid_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && start_i) |=> (row_q == $past(row_q) + 1'b1));
endmodule

// File: rtl/bw_limb_op.sv
module bw_limb_op
  import bw_pkg::*;
#(
  parameter int LIMB_W = 4
) (
  input  logic [LIMB_W-1:0] a_i,
  input  logic [LIMB_W-1:0] b_i,
  input  bw_op_e            op_i,
  output logic [LIMB_W-1:0] res_o
);
  for (genvar i = 0; i < LIMB_W; i++) begin : g_bit
    assign res_o[i] = (op_i == OP_XOR) ? (a_i[i] ^ b_i[i]) : (a_i[i] & b_i[i]);
  end
endmodule

// File: rtl/bw_nibble_unit.sv
module bw_nibble_unit
  import bw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LIMB_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              row_vld_o,
  output logic              k0_o,
  output logic              k1_o,
  output logic [DATA_W-1:0] a_acc_o,
  output logic [DATA_W-1:0] b_acc_o,
  output logic [LIMB_W-1:0] a_bits_o,
  output logic [LIMB_W-1:0] b_bits_o,
  output logic [DATA_W-1:0] zp_o,
  output logic [DATA_W-1:0] z_o,
  output logic              done_o
);
  localparam int ROWS = DATA_W / LIMB_W;
  localparam int HI_W = DATA_W - LIMB_W;

  logic accept, step;

  bw_row_ctrl #(.ROWS(ROWS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .accept_o(accept),
    .step_o  (step),
    .vld_o   (row_vld_o),
    .k0_o    (k0_o),
    .k1_o    (k1_o),
    .last_o  (done_o)
  );

  bw_op_e            sel_q, op_cur;
  logic [DATA_W-1:0] a_src_q, b_src_q;
  logic [DATA_W-1:0] a_acc_q, b_acc_q, zp_q, z_q;
  logic [LIMB_W-1:0] a_bits_q, b_bits_q;
  logic [LIMB_W-1:0] a_limb, b_limb, limb_res;

  // limb source: fresh operand on accept, else remaining shifted bits
  assign a_limb = accept ? a_i[DATA_W-1 -: LIMB_W] : a_src_q[DATA_W-1 -: LIMB_W];
  assign b_limb = accept ? b_i[DATA_W-1 -: LIMB_W] : b_src_q[DATA_W-1 -: LIMB_W];
  assign op_cur = accept ? bw_op_e'(sel_i) : sel_q;

  bw_limb_op #(.LIMB_W(LIMB_W)) u_op (
    .a_i  (a_limb),
    .b_i  (b_limb),
    .op_i (op_cur),
    .res_o(limb_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= OP_AND;
      a_src_q  <= '0;
      b_src_q  <= '0;
      a_acc_q  <= '0;
      b_acc_q  <= '0;
      a_bits_q <= '0;
      b_bits_q <= '0;
      zp_q     <= '0;
      z_q      <= '0;
    end else if (accept) begin
      sel_q    <= bw_op_e'(sel_i);
      a_src_q  <= a_i << LIMB_W;
      b_src_q  <= b_i << LIMB_W;
      a_acc_q  <= {{HI_W{1'b0}}, a_limb};
      b_acc_q  <= {{HI_W{1'b0}}, b_limb};
      a_bits_q <= a_limb;
      b_bits_q <= b_limb;
      zp_q     <= '0;
      z_q      <= {{HI_W{1'b0}}, limb_res};
    end else if (step) begin
      a_src_q  <= a_src_q << LIMB_W;
      b_src_q  <= b_src_q << LIMB_W;
      a_acc_q  <= {a_acc_q[HI_W-1:0], a_limb};
      b_acc_q  <= {b_acc_q[HI_W-1:0], b_limb};
      a_bits_q <= a_limb;
      b_bits_q <= b_limb;
      zp_q     <= z_q;
      z_q      <= {z_q[HI_W-1:0], limb_res};
    end
  end

  assign a_acc_o  = a_acc_q;
  assign b_acc_o  = b_acc_q;
  assign a_bits_o = a_bits_q;
  assign b_bits_o = b_bits_q;
  assign zp_o     = zp_q;
  assign z_o      = z_q;

  // R5
  zp_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k0_o |-> (zp_o == '0));
  // R5
  zp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k1_o |=> (zp_o == $past(z_o)));
  // R3
  acc_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k1_o |=> ((a_acc_o >> LIMB_W) == $past(a_acc_o)) && (a_acc_o[LIMB_W-1:0] == a_bits_o));
  // R6
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k1_o |=> (sel_q == $past(sel_q)));
  // R7
  done_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (row_vld_o && !k1_o));
  // R10
  idle_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (!row_vld_o && (z_o == $past(z_o))));
endmodule

// File: tb/sim_bw_nibble_unit.sv
module sim_bw_nibble_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 6;
  localparam int L    = 2;
  localparam int ROWS = W / L;
  localparam int W1   = 16;
  localparam int L1   = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         start, sel;
  logic [W-1:0] a, b;
  logic         vld, k0, k1, done;
  logic [W-1:0] a_acc, b_acc, zp, z;
  logic [L-1:0] a_bits, b_bits;

  bw_nibble_unit #(.DATA_W(W), .LIMB_W(L)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .sel_i(sel), .a_i(a), .b_i(b),
    .row_vld_o(vld), .k0_o(k0), .k1_o(k1), .a_acc_o(a_acc), .b_acc_o(b_acc),
    .a_bits_o(a_bits), .b_bits_o(b_bits), .zp_o(zp), .z_o(z), .done_o(done));

  logic          start1, sel1;
  logic [W1-1:0] a1, b1;
  logic          vld1, k01, k11, done1;
  logic [W1-1:0] a_acc1, b_acc1, zp1, z1;
  logic [L1-1:0] a_bits1, b_bits1;

  bw_nibble_unit #(.DATA_W(W1), .LIMB_W(L1)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start1), .sel_i(sel1), .a_i(a1), .b_i(b1),
    .row_vld_o(vld1), .k0_o(k01), .k1_o(k11), .a_acc_o(a_acc1), .b_acc_o(b_acc1),
    .a_bits_o(a_bits1), .b_bits_o(b_bits1), .zp_o(zp1), .z_o(z1), .done_o(done1));

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic launch(input int av, input int bv, input int s);
    start = 1'b1; a = W'(av); b = W'(bv); sel = s[0];
  endtask

  // follows an op accepted at the coming posedge; optional mid-op noise
  task automatic do_op(input int av, input int bv, input int s, input bit noise);
    int res;
    res = s ? (av ^ bv) : (av & bv);
    for (int r = 0; r < ROWS; r++) begin
      int sh;
      sh = W - (r + 1) * L;
      @(negedge clk);
      chk(vld == 1'b1, "R2 vld", int'(vld), 1);
      chk(k0 == (r == 0), "R2 k0", int'(k0), int'(r == 0));
      chk(k1 == (r < ROWS-1), "R2 k1", int'(k1), int'(r < ROWS-1));
      chk(int'(a_acc) == (av >> sh), "R3 a_acc", int'(a_acc), av >> sh);
      chk(int'(b_acc) == (bv >> sh), "R3 b_acc", int'(b_acc), bv >> sh);
      chk(int'(a_bits) == ((av >> sh) & 3), "R4 a_bits", int'(a_bits), (av >> sh) & 3);
      chk(int'(b_bits) == ((bv >> sh) & 3), "R4 b_bits", int'(b_bits), (bv >> sh) & 3);
      chk(int'(z) == (res >> sh), "R5 R6 z", int'(z), res >> sh);
      chk(int'(zp) == ((r == 0) ? 0 : (res >> (sh + L))), "R5 zp", int'(zp),
          (r == 0) ? 0 : (res >> (sh + L)));
      chk(done == (r == ROWS-1), "R7 done", int'(done), int'(r == ROWS-1));
      if (r < ROWS-1 && noise) begin
        // R8: ignored start with other operands and select
        start = 1'b1; a = W'($urandom); b = W'($urandom); sel = ~s[0];
      end else begin
        start = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int zexp[4];
    int aexp[4];
    start = 0; sel = 0; a = '0; b = '0;
    start1 = 0; sel1 = 0; a1 = '0; b1 = '0;
    repeat (2) @(negedge clk);
    // R1
    chk(!vld && !k0 && !k1 && !done, "R1 flags", int'({vld, k0, k1, done}), 0);
    chk(a_acc == 0 && b_acc == 0 && z == 0 && zp == 0, "R1 trace", int'(z), 0);
    chk(a_bits == 0 && b_bits == 0, "R1 bits", int'(a_bits), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R11 worked 16-bit AND case
    zexp = '{8, 129, 2070, 33130};
    aexp = '{10, 163, 2615, 41851};
    start1 = 1'b1; a1 = 16'd41851; b1 = 16'd40426; sel1 = 1'b0;
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      start1 = 1'b0;
      chk(int'(z1) == zexp[r], "R11 z", int'(z1), zexp[r]);
      chk(int'(a_acc1) == aexp[r], "R11 a_acc", int'(a_acc1), aexp[r]);
      chk(int'(zp1) == ((r == 0) ? 0 : zexp[r-1]), "R11 zp", int'(zp1),
          (r == 0) ? 0 : zexp[r-1]);
    end
    chk(done1 == 1'b1, "R11 done", int'(done1), 1);

    // exhaustive sweep; back-to-back chaining (R9), idle gap per a sweep (R10)
    for (int s = 0; s < 2; s++) begin
      for (int av = 0; av < (1 << W); av++) begin
        for (int bv = 0; bv < (1 << W); bv++) begin
          launch(av, bv, s);
          do_op(av, bv, s, bit'((av ^ bv) & 1));
        end
        @(negedge clk);
        // R10
        chk(!vld && !k0 && !k1 && !done, "R10 idle flags", int'({vld, k0, k1, done}), 0);
        chk(int'(z) == (s ? (av ^ 63) : (av & 63)), "R10 z held", int'(z),
            s ? (av ^ 63) : (av & 63));
        chk(int'(a_acc) == av, "R10 a_acc held", int'(a_acc), av);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule